// File: doc/BRIEF.md
# Slot-Based Memory Page Mapper

This block sits between an 8-bit CPU and its memories. It cuts the 64 KB CPU address space into four 16 KB pages. A byte-wide slot select register gives each page a 2-bit slot number. From the page and its slot number the block picks one target for each CPU access: a first ROM image, a second ROM image, a 64 KB RAM, or nothing. Space that maps to nothing reads as all ones and drops writes.

The slot select register is loaded through the output-port write path of a parallel peripheral interface. The CPU writes its select byte to port A. A read of port A returns the current select byte. A read of port B, which is the keyboard input, returns all ones because no key logic is attached. The memories are synchronous: a chip select and a local address go out in the strobe cycle, and read data is returned to the CPU one cycle later.

Top module: `slot_page_mapper`

## Requirements
- R1: After reset the select byte is 0x00. Page 0 then reads the first ROM, page 1 reads the second ROM, and pages 2 and 3 read 0xFF. A port A read returns 0x00.
- R2: The page is `cpu_addr[15:14]`. The slot number of page p is held in select bits [2p+1:2p]. Page 0 uses bits 1:0 and page 3 uses bits 7:6.
- R3: A write with `ppi_port` = 0 (port A) loads `ppi_wdata` into the select byte. The new mapping applies to a CPU access in the very next cycle.
- R4: Slot 0 on page 0 asserts `rom0_cs` on a read. Slot 0 on page 1 asserts `rom1_cs` on a read. In both cases `rom_addr` = `cpu_addr[13:0]`.
- R5: Slot 2 on any page n maps to RAM at offset n×16384. `ram_cs` is asserted with `ram_addr` = `cpu_addr`. `ram_we` is asserted on writes, and the written data reads back.
- R6: Every other page/slot pair is unpopulated. A read returns 0xFF and a write asserts no chip select and no write enable. At most one chip select is active at a time, and none is active without a strobe.
- R7: A write to a ROM-mapped page asserts no chip select and no write enable, and the ROM data reads back unchanged.
- R8: Read data appears on `cpu_rdata` in the cycle after the read strobe. `cpu_rdata` is 0xFF in any cycle that does not follow a read.
- R9: A read of port B (`ppi_port` = 1) returns 0xFF one cycle later. Writes to ports 1 to 3 leave the select byte unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cpu_addr | input | 16 | CPU address |
| cpu_rd | input | 1 | CPU read strobe, one cycle per access |
| cpu_wr | input | 1 | CPU write strobe; takes precedence over a read |
| cpu_wdata | input | 8 | CPU write data |
| cpu_rdata | output | 8 | Read data, one cycle after the strobe |
| ppi_port | input | 2 | Peripheral port index (0 = A, 1 = B, 2 = C, 3 = control) |
| ppi_wr | input | 1 | Peripheral port write strobe |
| ppi_rd | input | 1 | Peripheral port read strobe |
| ppi_wdata | input | 8 | Peripheral port write data |
| ppi_rdata | output | 8 | Peripheral port read data, one cycle after the strobe |
| rom0_cs | output | 1 | First ROM select |
| rom1_cs | output | 1 | Second ROM select |
| rom_addr | output | 14 | Local ROM address |
| rom0_rdata | input | 8 | First ROM data, registered in the ROM |
| rom1_rdata | input | 8 | Second ROM data, registered in the ROM |
| ram_cs | output | 1 | RAM select |
| ram_we | output | 1 | RAM write enable |
| ram_addr | output | 16 | RAM address |
| ram_wdata | output | 8 | RAM write data |
| ram_rdata | input | 8 | RAM data, registered in the RAM |

## Verification
Chip selects, write enables and local addresses are combinational, so the bench captures them 1 ns after it drives a strobe on a falling edge, before the next rising edge. Read data belongs to the rising edge after the strobe. The bench samples it at the next falling edge, and it also samples `cpu_rdata` in the strobe cycle itself and one cycle after the read, where 0xFF is expected. A select write is followed at once, with no idle cycle, by a CPU access, which shows that the new mapping applies in the next cycle. Port reads are sampled one falling edge after their strobe.

// File: rtl/slot_map_pkg.sv
// Shared types and constants for the slot page mapper.
// Assumes a peripheral interface with four port indices.
package slot_map_pkg;

    typedef enum logic [1:0] {
        TGT_NONE = 2'd0,
        TGT_ROM0 = 2'd1,
        TGT_ROM1 = 2'd2,
        TGT_RAM  = 2'd3
    } tgt_e;

    localparam logic [1:0] PORT_SEL = 2'd0;
    localparam logic [1:0] PORT_KEY = 2'd1;

endpackage

// File: rtl/slot_select_reg.sv
// Slot select register behind the peripheral port interface.
// It loads the select byte on a port A write, returns the select byte on a port A read,
// and returns all ones for any other port read. Assumes SEL_W <= DATA_W.
module slot_select_reg
    import slot_map_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int SEL_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        ppi_port,
    input  logic              ppi_wr,
    input  logic              ppi_rd,
    input  logic [DATA_W-1:0] ppi_wdata,
    output logic [DATA_W-1:0] ppi_rdata,
    output logic [SEL_W-1:0]  sel_q
);

    logic [DATA_W-1:0] rd_value;

    // Holds the select byte; only a port A write changes it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_q <= '0;
        end else if (ppi_wr && ppi_port == PORT_SEL) begin
            sel_q <= ppi_wdata[SEL_W-1:0];
        end
    end

    // Chooses the value a port read would return.
    always_comb begin
        rd_value = '1;
        if (ppi_port == PORT_SEL) begin
            rd_value = '0;
            rd_value[SEL_W-1:0] = sel_q;
        end
    end

    // Registers port read data one cycle after the read strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ppi_rdata <= '0;
        end else if (ppi_rd) begin
            ppi_rdata <= rd_value;
        end
    end

endmodule

// File: rtl/page_router.sv
// Per-page target lookup.
// Each page's slot field is decoded into a target, then the entry for the page
// being accessed is selected. Only the ROM pages and the RAM slot are populated.
module page_router
    import slot_map_pkg::*;
#(
    parameter int PAGE_W    = 2,
    parameter int SLOT_W    = 2,
    parameter int ROM_SLOT  = 0,
    parameter int RAM_SLOT  = 2,
    parameter int ROM0_PAGE = 0,
    parameter int ROM1_PAGE = 1,
    localparam int NUM_PAGES = 1 << PAGE_W,
    localparam int SEL_W     = NUM_PAGES * SLOT_W
) (
    input  logic [SEL_W-1:0]  sel_q,
    input  logic [PAGE_W-1:0] page_idx,
    output tgt_e              tgt
);

    tgt_e page_tgt [NUM_PAGES];

    for (genvar p = 0; p < NUM_PAGES; p++) begin : g_page
        logic [SLOT_W-1:0] slot;
        assign slot = sel_q[p*SLOT_W +: SLOT_W];

        // Decodes the slot number of page p into a memory target.
        always_comb begin
            page_tgt[p] = TGT_NONE;
            if (slot == SLOT_W'(RAM_SLOT)) begin
                page_tgt[p] = TGT_RAM;
            end else if (slot == SLOT_W'(ROM_SLOT) && p == ROM0_PAGE) begin
                page_tgt[p] = TGT_ROM0;
            end else if (slot == SLOT_W'(ROM_SLOT) && p == ROM1_PAGE) begin
                page_tgt[p] = TGT_ROM1;
            end
        end
    end

    // Picks the target of the page under the current address.
    always_comb begin
        tgt = page_tgt[page_idx];
    end

endmodule

// File: rtl/bus_steer.sv
// Drives chip selects, write enable and local addresses from the chosen target.
// A write takes precedence over a read. ROM targets are never written.
module bus_steer
    import slot_map_pkg::*;
#(
    parameter int ADDR_W  = 16,
    parameter int DATA_W  = 8,
    parameter int LOCAL_W = 14
) (
    input  tgt_e              tgt,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic              cpu_rd,
    input  logic              cpu_wr,
    input  logic [DATA_W-1:0] cpu_wdata,
    output logic              rd_act,
    output logic              rom0_cs,
    output logic              rom1_cs,
    output logic [LOCAL_W-1:0] rom_addr,
    output logic              ram_cs,
    output logic              ram_we,
    output logic [ADDR_W-1:0] ram_addr,
    output logic [DATA_W-1:0] ram_wdata
);

    // Gates each chip select with the strobe the target accepts.
    always_comb begin
        rd_act    = cpu_rd && !cpu_wr;
        rom0_cs   = rd_act && (tgt == TGT_ROM0);
        rom1_cs   = rd_act && (tgt == TGT_ROM1);
        ram_cs    = (rd_act || cpu_wr) && (tgt == TGT_RAM);
        ram_we    = cpu_wr && (tgt == TGT_RAM);
        rom_addr  = cpu_addr[LOCAL_W-1:0];
        ram_addr  = cpu_addr;
        ram_wdata = cpu_wdata;
    end

endmodule

// File: rtl/read_return.sv
// Records which target a read went to and routes its data back one cycle later.
// Unpopulated reads and cycles after no read return all ones.
module read_return
    import slot_map_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_act,
    input  tgt_e              tgt,
    input  logic [DATA_W-1:0] rom0_rdata,
    input  logic [DATA_W-1:0] rom1_rdata,
    input  logic [DATA_W-1:0] ram_rdata,
    output logic [DATA_W-1:0] cpu_rdata
);

    tgt_e src_q;

    // Remembers the source of the read that is in flight.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            src_q <= TGT_NONE;
        end else begin
            src_q <= rd_act ? tgt : TGT_NONE;
        end
    end

    // Selects returned data by the recorded source.
    always_comb begin
        unique case (src_q)
            TGT_ROM0: cpu_rdata = rom0_rdata;
            TGT_ROM1: cpu_rdata = rom1_rdata;
            TGT_RAM:  cpu_rdata = ram_rdata;
            default:  cpu_rdata = '1;
        endcase
    end

endmodule

// File: rtl/slot_page_mapper.sv
// Top of the slot page mapper.
// Splits the CPU space into pages, maps each page through its slot field,
// and connects the CPU to two ROMs and a RAM. Assumes synchronous memories.
module slot_page_mapper
    import slot_map_pkg::*;
#(
    parameter int ADDR_W    = 16,
    parameter int DATA_W    = 8,
    parameter int PAGE_W    = 2,
    parameter int SLOT_W    = 2,
    parameter int ROM_SLOT  = 0,
    parameter int RAM_SLOT  = 2,
    parameter int ROM0_PAGE = 0,
    parameter int ROM1_PAGE = 1,
    localparam int NUM_PAGES = 1 << PAGE_W,
    localparam int SEL_W     = NUM_PAGES * SLOT_W,
    localparam int LOCAL_W   = ADDR_W - PAGE_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [ADDR_W-1:0]  cpu_addr,
    input  logic               cpu_rd,
    input  logic               cpu_wr,
    input  logic [DATA_W-1:0]  cpu_wdata,
    output logic [DATA_W-1:0]  cpu_rdata,
    input  logic [1:0]         ppi_port,
    input  logic               ppi_wr,
    input  logic               ppi_rd,
    input  logic [DATA_W-1:0]  ppi_wdata,
    output logic [DATA_W-1:0]  ppi_rdata,
    output logic               rom0_cs,
    output logic               rom1_cs,
    output logic [LOCAL_W-1:0] rom_addr,
    input  logic [DATA_W-1:0]  rom0_rdata,
    input  logic [DATA_W-1:0]  rom1_rdata,
    output logic               ram_cs,
    output logic               ram_we,
    output logic [ADDR_W-1:0]  ram_addr,
    output logic [DATA_W-1:0]  ram_wdata,
    input  logic [DATA_W-1:0]  ram_rdata
);

    logic [SEL_W-1:0] sel_q;
    tgt_e             tgt;
    logic             rd_act;

    slot_select_reg #(.DATA_W(DATA_W), .SEL_W(SEL_W)) u_sel (
        .clk       (clk),
        .rst_n     (rst_n),
        .ppi_port  (ppi_port),
        .ppi_wr    (ppi_wr),
        .ppi_rd    (ppi_rd),
        .ppi_wdata (ppi_wdata),
        .ppi_rdata (ppi_rdata),
        .sel_q     (sel_q)
    );

    page_router #(
        .PAGE_W    (PAGE_W),
        .SLOT_W    (SLOT_W),
        .ROM_SLOT  (ROM_SLOT),
        .RAM_SLOT  (RAM_SLOT),
        .ROM0_PAGE (ROM0_PAGE),
        .ROM1_PAGE (ROM1_PAGE)
    ) u_route (
        .sel_q    (sel_q),
        .page_idx (cpu_addr[ADDR_W-1 -: PAGE_W]),
        .tgt      (tgt)
    );

    bus_steer #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .LOCAL_W(LOCAL_W)) u_steer (
        .tgt       (tgt),
        .cpu_addr  (cpu_addr),
        .cpu_rd    (cpu_rd),
        .cpu_wr    (cpu_wr),
        .cpu_wdata (cpu_wdata),
        .rd_act    (rd_act),
        .rom0_cs   (rom0_cs),
        .rom1_cs   (rom1_cs),
        .rom_addr  (rom_addr),
        .ram_cs    (ram_cs),
        .ram_we    (ram_we),
        .ram_addr  (ram_addr),
        .ram_wdata (ram_wdata)
    );

    read_return #(.DATA_W(DATA_W)) u_ret (
        .clk        (clk),
        .rst_n      (rst_n),
        .rd_act     (rd_act),
        .tgt        (tgt),
        .rom0_rdata (rom0_rdata),
        .rom1_rdata (rom1_rdata),
        .ram_rdata  (ram_rdata),
        .cpu_rdata  (cpu_rdata)
    );

endmodule

// File: rtl/slot_page_mapper_chk.sv
// Property checker for the slot page mapper. It is bound to the top module and
// observes its ports and the select byte.
module slot_page_mapper_chk
    import slot_map_pkg::*;
#(
    parameter int ADDR_W    = 16,
    parameter int DATA_W    = 8,
    parameter int PAGE_W    = 2,
    parameter int SLOT_W    = 2,
    parameter int ROM_SLOT  = 0,
    parameter int ROM0_PAGE = 0,
    parameter int ROM1_PAGE = 1,
    localparam int SEL_W    = (1 << PAGE_W) * SLOT_W,
    localparam int LOCAL_W  = ADDR_W - PAGE_W
) (
    input logic               clk,
    input logic               rst_n,
    input logic [ADDR_W-1:0]  cpu_addr,
    input logic               cpu_rd,
    input logic               cpu_wr,
    input logic [DATA_W-1:0]  cpu_rdata,
    input logic [1:0]         ppi_port,
    input logic               ppi_wr,
    input logic               ppi_rd,
    input logic [DATA_W-1:0]  ppi_wdata,
    input logic [DATA_W-1:0]  ppi_rdata,
    input logic               rom0_cs,
    input logic               rom1_cs,
    input logic [LOCAL_W-1:0] rom_addr,
    input logic               ram_cs,
    input logic               ram_we,
    input logic [ADDR_W-1:0]  ram_addr,
    input logic [SEL_W-1:0]   sel_q
);

    assert_reset_sel_R1: assert property (@(posedge clk)
        !rst_n |=> sel_q == '0);

    assert_port_a_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (ppi_wr && ppi_port == PORT_SEL) |=> sel_q == $past(ppi_wdata[SEL_W-1:0]));

    assert_rom0_window_R4: assert property (@(posedge clk) disable iff (!rst_n)
        rom0_cs |-> (cpu_addr[ADDR_W-1 -: PAGE_W] == PAGE_W'(ROM0_PAGE)
                     && sel_q[ROM0_PAGE*SLOT_W +: SLOT_W] == SLOT_W'(ROM_SLOT)
                     && rom_addr == cpu_addr[LOCAL_W-1:0]));

    assert_rom1_window_R4: assert property (@(posedge clk) disable iff (!rst_n)
        rom1_cs |-> (cpu_addr[ADDR_W-1 -: PAGE_W] == PAGE_W'(ROM1_PAGE)
                     && sel_q[ROM1_PAGE*SLOT_W +: SLOT_W] == SLOT_W'(ROM_SLOT)));

    assert_ram_addr_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ram_cs |-> (ram_addr == cpu_addr && ram_we == cpu_wr));

    assert_single_target_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({rom0_cs, rom1_cs, ram_cs}));

    assert_no_strobe_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!cpu_rd && !cpu_wr) |-> !(rom0_cs || rom1_cs || ram_cs || ram_we));

    assert_rom_no_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (rom0_cs || rom1_cs) |-> !cpu_wr);

    assert_idle_return_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !cpu_rd |=> cpu_rdata == '1);

    assert_port_b_ones_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (ppi_rd && ppi_port == PORT_KEY) |=> ppi_rdata == '1);

    assert_other_port_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !(ppi_wr && ppi_port == PORT_SEL) |=> $stable(sel_q));

endmodule

bind slot_page_mapper slot_page_mapper_chk #(
    .ADDR_W    (ADDR_W),
    .DATA_W    (DATA_W),
    .PAGE_W    (PAGE_W),
    .SLOT_W    (SLOT_W),
    .ROM_SLOT  (ROM_SLOT),
    .ROM0_PAGE (ROM0_PAGE),
    .ROM1_PAGE (ROM1_PAGE)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cpu_addr  (cpu_addr),
    .cpu_rd    (cpu_rd),
    .cpu_wr    (cpu_wr),
    .cpu_rdata (cpu_rdata),
    .ppi_port  (ppi_port),
    .ppi_wr    (ppi_wr),
    .ppi_rd    (ppi_rd),
    .ppi_wdata (ppi_wdata),
    .ppi_rdata (ppi_rdata),
    .rom0_cs   (rom0_cs),
    .rom1_cs   (rom1_cs),
    .rom_addr  (rom_addr),
    .ram_cs    (ram_cs),
    .ram_we    (ram_we),
    .ram_addr  (ram_addr),
    .sel_q     (sel_q)
);

// File: tb/slot_page_mapper_test.sv
// Directed bench for the slot page mapper with small synchronous memory models.
module slot_page_mapper_test;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [15:0] cpu_addr;
    logic        cpu_rd, cpu_wr;
    logic [7:0]  cpu_wdata, cpu_rdata;
    logic [1:0]  ppi_port;
    logic        ppi_wr, ppi_rd;
    logic [7:0]  ppi_wdata, ppi_rdata;
    logic        rom0_cs, rom1_cs, ram_cs, ram_we;
    logic [13:0] rom_addr;
    logic [7:0]  rom0_rdata, rom1_rdata, ram_rdata, ram_wdata;
    logic [15:0] ram_addr;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    slot_page_mapper uut (
        .clk(clk), .rst_n(rst_n),
        .cpu_addr(cpu_addr), .cpu_rd(cpu_rd), .cpu_wr(cpu_wr),
        .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
        .ppi_port(ppi_port), .ppi_wr(ppi_wr), .ppi_rd(ppi_rd),
        .ppi_wdata(ppi_wdata), .ppi_rdata(ppi_rdata),
        .rom0_cs(rom0_cs), .rom1_cs(rom1_cs), .rom_addr(rom_addr),
        .rom0_rdata(rom0_rdata), .rom1_rdata(rom1_rdata),
        .ram_cs(ram_cs), .ram_we(ram_we), .ram_addr(ram_addr),
        .ram_wdata(ram_wdata), .ram_rdata(ram_rdata)
    );

    // Memory models: ROM data is a function of the address; RAM keeps 64 bytes per quarter.
    logic [7:0] ram_mem [256];
    function automatic logic [7:0] rom0_val(input logic [13:0] a); return a[7:0] ^ 8'h5A; endfunction
    function automatic logic [7:0] rom1_val(input logic [13:0] a); return a[7:0] ^ 8'hC3; endfunction

    always @(posedge clk) begin
        if (rom0_cs) rom0_rdata <= rom0_val(rom_addr);
        if (rom1_cs) rom1_rdata <= rom1_val(rom_addr);
        if (ram_cs) begin
            if (ram_we) ram_mem[{ram_addr[15:14], ram_addr[5:0]}] <= ram_wdata;
            ram_rdata <= ram_mem[{ram_addr[15:14], ram_addr[5:0]}];
        end
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Each bus task starts and ends on a falling edge.
    task automatic cpu_read(input logic [15:0] a, output logic [7:0] d, output logic [7:0] pre);
        cpu_addr = a; cpu_rd = 1'b1;
        #1 pre = cpu_rdata;
        @(negedge clk);
        d = cpu_rdata;
        cpu_rd = 1'b0;
    endtask

    task automatic cpu_write(input logic [15:0] a, input logic [7:0] d, output logic [3:0] strobes,
                             output logic [15:0] ra);
        cpu_addr = a; cpu_wdata = d; cpu_wr = 1'b1;
        #1 strobes = {rom0_cs, rom1_cs, ram_cs, ram_we};
        ra = ram_addr;
        @(negedge clk);
        cpu_wr = 1'b0;
    endtask

    task automatic port_write(input logic [1:0] p, input logic [7:0] d);
        ppi_port = p; ppi_wdata = d; ppi_wr = 1'b1;
        @(negedge clk);
        ppi_wr = 1'b0;
    endtask

    task automatic port_read(input logic [1:0] p, output logic [7:0] d);
        ppi_port = p; ppi_rd = 1'b1;
        @(negedge clk);
        d = ppi_rdata;
        ppi_rd = 1'b0;
    endtask

    task automatic test_reset;
        logic [7:0] d, pre;
        chk(cpu_rdata == 8'hFF, "R1 rdata in reset", cpu_rdata, 8'hFF);
        port_read(2'd0, d);
        chk(d == 8'h00, "R1 select after reset", d, 8'h00);
        cpu_read(16'h0010, d, pre);
        chk(d == rom0_val(14'h10), "R1 page0 rom0", d, rom0_val(14'h10));
        cpu_read(16'h4020, d, pre);
        chk(d == rom1_val(14'h20), "R1 R4 page1 rom1", d, rom1_val(14'h20));
        cpu_read(16'h8000, d, pre);
        chk(d == 8'hFF, "R1 page2 empty", d, 8'hFF);
        cpu_read(16'hC000, d, pre);
        chk(d == 8'hFF, "R1 page3 empty", d, 8'hFF);
    endtask

    task automatic test_rom_write;
        logic [3:0] s; logic [15:0] ra; logic [7:0] d, pre;
        cpu_write(16'h0005, 8'h11, s, ra);
        chk(s == 4'b0000, "R7 rom write strobes", s, 4'b0000);
        cpu_read(16'h0005, d, pre);
        chk(d == rom0_val(14'h5), "R7 rom unchanged", d, rom0_val(14'h5));
        cpu_write(16'h8003, 8'h99, s, ra);
        chk(s == 4'b0000, "R6 empty write strobes", s, 4'b0000);
    endtask

    task automatic test_all_ram;
        logic [3:0] s; logic [15:0] ra; logic [7:0] d, pre;
        port_write(2'd0, 8'hAA);
        cpu_write(16'h0003, 8'h10, s, ra);
        chk(s == 4'b0011, "R3 R5 next-cycle ram write", s, 4'b0011);
        chk(ra == 16'h0003, "R5 ram addr page0", ra, 16'h0003);
        cpu_write(16'h4003, 8'h21, s, ra);
        cpu_write(16'h8003, 8'h32, s, ra);
        chk(ra == 16'h8003, "R5 ram addr page2", ra, 16'h8003);
        cpu_write(16'hC003, 8'h43, s, ra);
        cpu_read(16'h0003, d, pre);  chk(d == 8'h10, "R5 ram page0", d, 8'h10);
        cpu_read(16'h4003, d, pre);  chk(d == 8'h21, "R5 ram page1", d, 8'h21);
        cpu_read(16'h8003, d, pre);  chk(d == 8'h32, "R5 ram page2", d, 8'h32);
        cpu_read(16'hC003, d, pre);  chk(d == 8'h43, "R5 ram page3", d, 8'h43);
    endtask

    task automatic test_fields;
        logic [7:0] d, pre;
        // page0 slot1, page1 slot2, page2 slot0, page3 slot2
        port_write(2'd0, 8'b10_00_10_01);
        cpu_read(16'h0003, d, pre);  chk(d == 8'hFF, "R2 R6 page0 slot1", d, 8'hFF);
        cpu_read(16'h4003, d, pre);  chk(d == 8'h21, "R2 page1 slot2", d, 8'h21);
        cpu_read(16'h8003, d, pre);  chk(d == 8'hFF, "R2 R6 page2 slot0", d, 8'hFF);
        cpu_read(16'hC003, d, pre);  chk(d == 8'h43, "R2 page3 slot2", d, 8'h43);
        // page0 slot2, page1 slot0, page2 slot2, page3 slot0
        port_write(2'd0, 8'b00_10_00_10);
        cpu_read(16'h0003, d, pre);  chk(d == 8'h10, "R2 page0 slot2", d, 8'h10);
        cpu_read(16'h4007, d, pre);  chk(d == rom1_val(14'h7), "R2 R4 page1 slot0", d, rom1_val(14'h7));
        cpu_read(16'h8003, d, pre);  chk(d == 8'h32, "R2 page2 slot2", d, 8'h32);
        cpu_read(16'hC003, d, pre);  chk(d == 8'hFF, "R2 R6 page3 slot0", d, 8'hFF);
        port_write(2'd0, 8'hFF);
        cpu_read(16'h0003, d, pre);  chk(d == 8'hFF, "R6 slot3 page0", d, 8'hFF);
        cpu_read(16'h4003, d, pre);  chk(d == 8'hFF, "R6 slot3 page1", d, 8'hFF);
    endtask

    task automatic test_latency;
        logic [7:0] d, pre;
        port_write(2'd0, 8'h00);
        @(negedge clk);
        cpu_read(16'h0021, d, pre);
        chk(pre == 8'hFF, "R8 strobe-cycle rdata", pre, 8'hFF);
        chk(d == rom0_val(14'h21), "R8 data next cycle", d, rom0_val(14'h21));
        @(negedge clk);
        chk(cpu_rdata == 8'hFF, "R8 idle after read", cpu_rdata, 8'hFF);
    endtask

    task automatic test_ports;
        logic [7:0] d;
        port_write(2'd0, 8'h8C);
        port_read(2'd1, d);  chk(d == 8'hFF, "R9 port B ones", d, 8'hFF);
        port_write(2'd2, 8'h00);
        port_write(2'd1, 8'h33);
        port_write(2'd3, 8'h55);
        port_read(2'd0, d);  chk(d == 8'h8C, "R9 other ports ignored", d, 8'h8C);
    endtask

    initial begin
        rst_n = 1'b0; cpu_addr = '0; cpu_rd = 1'b0; cpu_wr = 1'b0; cpu_wdata = '0;
        ppi_port = '0; ppi_wr = 1'b0; ppi_rd = 1'b0; ppi_wdata = '0;
        for (int i = 0; i < 256; i++) ram_mem[i] = 8'h00;
        repeat (3) @(posedge clk);
        @(negedge clk);
        test_reset_hold();
        rst_n = 1'b1;
        test_reset();
        test_rom_write();
        test_all_ram();
        test_fields();
        test_latency();
        test_ports();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    task automatic test_reset_hold;
        chk({rom0_cs, rom1_cs, ram_cs, ram_we} == 4'b0000, "R1 no selects in reset",
            {rom0_cs, rom1_cs, ram_cs, ram_we}, 4'b0000);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++; fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule